// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between the data side of a 32-bit integer pipeline and a byte-addressable memory built from 32-bit words. For each request it adds a base register and a sign-extended 16-bit displacement to get the effective address. The two low bits of that address are dropped to give the word address presented to memory. For stores it places the source bits on the correct byte lanes and raises only the matching write enables. For loads it issues a read, then takes the addressed byte, halfword or word out of the word that memory returns one cycle later, and sign-extends it to 32 bits.

Lanes are big-endian: byte offset 0 of a word sits on bits 31..24. A request whose address does not suit its access size is flagged as misaligned and does not reach memory. The memory port is a plain synchronous one: write enables and read strobe act at the clock edge, and read data is valid in the following cycle.

Top module: `ldst_align`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits (arithmetic modulo 2^32). `mem_addr` carries its bits 31..2, combinationally, in the cycle of the request.
- R2: A word store (`req_size` = 2'b10 or 2'b11) at an address with bits 1..0 = 0 drives `mem_we` = 4'b1111 and `mem_wdata` = `st_data`, and leaves `mem_re` low.
- R3: A halfword store (`req_size` = 2'b01) at an even address drives `mem_we` = 4'b1100 for address bit 1 = 0, or 4'b0011 for address bit 1 = 1. `mem_wdata` is `st_data[15:0]` repeated in both halves.
- R4: A byte store (`req_size` = 2'b00) with address bits 1..0 = k drives `mem_we` = 4'b1000 >> k. `mem_wdata` is `st_data[7:0]` repeated in all four lanes. A byte access is never misaligned.
- R5: A halfword request with address bit 0 set, or a word request with nonzero address bits 1..0, raises `misalign` in that cycle. Such a request keeps `mem_we` at 0 and `mem_re` low, so memory contents are unchanged and no load result follows.
- R6: An aligned load request raises `mem_re` with `mem_we` = 0. `ld_valid` is high for exactly the following cycle, and at no other time.
- R7: A word load returns the full memory word on `ld_data`.
- R8: A halfword load returns bits 31..16 (address bit 1 = 0) or bits 15..0 (address bit 1 = 1) of the memory word, sign-extended to 32 bits.
- R9: A byte load with address bits 1..0 = k returns bits (31-8k)..(24-8k) of the memory word, sign-extended to 32 bits.
- R10: In reset, and in any cycle without `req_valid`, `mem_we` is 0 and `mem_re` and `misalign` are low. `ld_valid` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Store source register |
| mem_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 4 | Lane write enables, bit 3 = bits 31..24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned the cycle after `mem_re` |
| misalign | output | 1 | Request address unsuitable for its size |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The checker watches, on every cycle, the relationships between the port groups. A flagged request never touches memory, and idle cycles are quiet. Stores raise one lane for a byte and two lanes for a halfword and never read. A load result appears exactly one cycle after a read strobe and never otherwise. The scenarios in the bench are needed for the values themselves: effective addresses that carry or borrow across the displacement, which lane each offset selects, the sign of extended loads, and the unchanged memory after a rejected store, read back through a later load.

// File: rtl/ldst_align.sv
module ldst_align #(
  parameter int AW    = 32,
  parameter int OFF_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] base,
  input  logic [OFF_W-1:0] offset,
  input  logic [31:0]   st_data,
  output logic [AW-3:0] mem_addr,
  output logic          mem_re,
  output logic [3:0]    mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          misalign,
  output logic          ld_valid,
  output logic [31:0]   ld_data
);

  localparam int EXT_W = AW - OFF_W;

  logic [AW-1:0] ea;
  logic [1:0]    lane;
  logic          is_byte, is_half, is_word, bad, ok;

  assign ea       = base + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane     = ea[1:0];
  assign mem_addr = ea[AW-1:2];

  assign is_byte = (req_size == 2'b00);
  assign is_half = (req_size == 2'b01);
  assign is_word = req_size[1];

  assign bad      = (is_half & lane[0]) | (is_word & (lane != 2'b00));
  assign misalign = req_valid & bad;
  assign ok       = req_valid & ~bad;
  assign mem_re   = ok & ~req_store;

  always_comb begin
    mem_we = 4'b0000;
    if (ok && req_store) begin
      if (is_byte)      mem_we = 4'b1000 >> lane;
      else if (is_half) mem_we = lane[1] ? 4'b0011 : 4'b1100;
      else              mem_we = 4'b1111;
    end
  end

  assign mem_wdata = is_byte ? {4{st_data[7:0]}} :
                     is_half ? {2{st_data[15:0]}} : st_data;

  logic       pend_q;
  logic [1:0] lane_q;
  logic [1:0] size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lane_q <= 2'b00;
      size_q <= 2'b00;
    end else begin
      pend_q <= mem_re;
      if (mem_re) begin
        lane_q <= lane;
        size_q <= req_size;
      end
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    case (lane_q)
      2'd0:    sel_b = mem_rdata[31:24];
      2'd1:    sel_b = mem_rdata[23:16];
      2'd2:    sel_b = mem_rdata[15:8];
      default: sel_b = mem_rdata[7:0];
    endcase
  end

  assign sel_h = lane_q[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  assign ld_valid = pend_q;
  assign ld_data  = size_q[1]          ? mem_rdata :
                    (size_q == 2'b01)  ? {{16{sel_h[15]}}, sel_h} :
                                         {{24{sel_b[7]}}, sel_b};

endmodule

module ldst_align_chk #(
  parameter int AW    = 32,
  parameter int OFF_W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_store,
  input logic [1:0]    req_size,
  input logic          mem_re,
  input logic [3:0]    mem_we,
  input logic          misalign,
  input logic          ld_valid
);

  assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_we == 4'b0000 && !mem_re));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_we == 4'b0000 && !mem_re && !misalign));

  assert_store_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |-> !mem_re);

  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b00) |-> ($countones(mem_we) == 1 && !misalign));

  assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b01 && !misalign) |-> ($countones(mem_we) == 2));

  assert_read_then_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid);

  assert_result_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_re));

  assert_load_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_we == 4'b0000));

endmodule

bind ldst_align ldst_align_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_ldst_align.sv
module tb_ldst_align;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = '0, st_data = '0;
  logic [15:0] offset = '0;
  logic [29:0] mem_addr;
  logic        mem_re, misalign, ld_valid;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata, mem_rdata, ld_data;

  always #(CLK_T/2) clk = ~clk;

  ldst_align dut (.*);

  logic [31:0] ram [16];
  logic [31:0] shadow [16];
  logic [31:0] rd_q = '0;
  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (mem_re) rd_q <= ram[mem_addr[3:0]];
    for (int i = 0; i < 4; i++)
      if (mem_we[i]) ram[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
  end

  typedef struct {
    logic [29:0] addr; logic re; logic [3:0] we; logic [31:0] wd; logic mis; string tag;
  } req_exp_t;
  typedef struct { logic [31:0] d; string tag; } ld_exp_t;

  req_exp_t sq[$];
  ld_exp_t  lq[$];
  int checks = 0, errors = 0;

  task automatic do_req(input logic st, input logic [1:0] sz, input logic [31:0] b,
                        input logic [15:0] off, input logic [31:0] d, input string tag);
    req_exp_t e;
    ld_exp_t  l;
    logic [31:0] ea, w;
    logic [1:0]  k;
    ea = b + {{16{off[15]}}, off};
    k  = ea[1:0];
    e.tag = tag; e.addr = ea[31:2];
    e.mis = (sz == 2'b01) ? k[0] : (sz[1] ? (k != 2'b00) : 1'b0);
    e.re  = !st && !e.mis;
    e.we  = 4'b0000; e.wd = 32'h0;
    if (st && !e.mis) begin
      for (int i = 0; i < 4; i++) begin
        int bo;
        bo = 3 - i;
        if (sz == 2'b00 && bo == int'(k)) begin
          e.we[i] = 1'b1; shadow[ea[5:2]][8*i +: 8] = d[7:0];
        end else if (sz == 2'b01 && (bo >> 1) == int'(k[1])) begin
          e.we[i] = 1'b1; shadow[ea[5:2]][8*i +: 8] = d[8*(i%2) +: 8];
        end else if (sz[1]) begin
          e.we[i] = 1'b1; shadow[ea[5:2]][8*i +: 8] = d[8*i +: 8];
        end
      end
      e.wd = (sz == 2'b00) ? {d[7:0], d[7:0], d[7:0], d[7:0]} :
             (sz == 2'b01) ? {d[15:0], d[15:0]} : d;
    end
    if (e.re) begin
      w = shadow[ea[5:2]];
      l.tag = tag;
      if (sz[1]) l.d = w;
      else if (sz == 2'b01) begin
        w = k[1] ? w : (w >> 16);
        l.d = {{16{w[15]}}, w[15:0]};
      end else begin
        w = w >> (8 * (3 - int'(k)));
        l.d = {{24{w[7]}}, w[7:0]};
      end
      lq.push_back(l);
    end
    sq.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_store = st; req_size = sz; base = b; offset = off; st_data = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; st_data = 32'hDEAD_BEEF;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (req_valid) begin
      checks++;
      if (sq.size() == 0) begin
        errors++; $display("FAIL unexpected request R1 actual=request expected=none");
      end else begin
        req_exp_t e;
        e = sq.pop_front();
        if (misalign !== e.mis || mem_re !== e.re || mem_we !== e.we ||
            (!e.mis && mem_addr !== e.addr) || (e.we != 0 && mem_wdata !== e.wd)) begin
          errors++;
          $display("FAIL %s actual mis=%b re=%b we=%b addr=%h wd=%h expected mis=%b re=%b we=%b addr=%h wd=%h",
                   e.tag, misalign, mem_re, mem_we, mem_addr, mem_wdata,
                   e.mis, e.re, e.we, e.addr, e.wd);
        end
      end
    end else begin
      checks++;
      if (mem_we !== 4'b0000 || mem_re !== 1'b0 || misalign !== 1'b0) begin
        errors++; $display("FAIL R10 idle actual we=%b re=%b mis=%b expected 0000 0 0", mem_we, mem_re, misalign);
      end
    end
    if (ld_valid) begin
      checks++;
      if (lq.size() == 0) begin
        errors++; $display("FAIL R6 actual ld_valid=1 expected ld_valid=0");
      end else begin
        ld_exp_t l;
        l = lq.pop_front();
        if (ld_data !== l.d) begin
          errors++; $display("FAIL %s actual ld_data=%h expected %h", l.tag, ld_data, l.d);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_T * 100000);
    errors++; checks++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i] = 32'h0; shadow[i] = 32'h0;
    end
    #(CLK_T * 3 + 2);
    checks++;
    if (ld_valid !== 1'b0 || mem_we !== 4'b0000 || mem_re !== 1'b0) begin
      errors++; $display("FAIL R10 reset actual ldv=%b we=%b re=%b expected 0 0000 0", ld_valid, mem_we, mem_re);
    end
    rst_n = 1'b1;
    idle();
    do_req(1, 2'b10, 32'h20, 16'hFFF0, 32'hA1B2C3D4, "R1 R2 word store negative offset");
    do_req(1, 2'b10, 32'h0,  16'h0008, 32'h11223344, "R2 word store");
    do_req(0, 2'b10, 32'h14, 16'hFFFC, 32'h0, "R7 word load");
    do_req(1, 2'b01, 32'h4,  16'h0004, 32'hFFFF8001, "R3 half store upper");
    do_req(1, 2'b01, 32'h4,  16'h0006, 32'h00007FFE, "R3 half store lower");
    do_req(0, 2'b01, 32'h8,  16'h0000, 32'h0, "R8 half load negative");
    do_req(0, 2'b01, 32'h8,  16'h0002, 32'h0, "R8 half load positive");
    for (int k = 0; k < 4; k++)
      do_req(1, 2'b00, 32'h14, 16'(k), 32'h0000_0080 + 32'(k * 33), "R4 byte store lane");
    for (int k = 0; k < 4; k++)
      do_req(0, 2'b00, 32'h10, 16'(4 + k), 32'h0, "R9 byte load lane");
    do_req(0, 2'b00, 32'h13, 16'h0000, 32'h0, "R9 byte load negative");
    do_req(1, 2'b01, 32'h9,  16'h0000, 32'h5555, "R5 half store odd");
    do_req(1, 2'b10, 32'h12, 16'h0000, 32'h77777777, "R5 word store low bits");
    do_req(0, 2'b11, 32'h11, 16'h0000, 32'h0, "R5 word load misaligned");
    idle();
    idle();
    do_req(0, 2'b10, 32'h8,  16'h0000, 32'h0, "R5 memory unchanged after rejected store");
    do_req(0, 2'b10, 32'h10, 16'h0000, 32'h0, "R5 word unchanged");
    do_req(1, 2'b11, 32'h40, 16'hFFFC, 32'hCAFEF00D, "R1 R2 borrow across word");
    do_req(0, 2'b10, 32'h38, 16'h0004, 32'h0, "R7 readback");
    do_req(1, 2'b00, 32'h1,  16'h0000, 32'h000000F7, "R4 byte odd address aligned");
    idle();
    idle();
    idle();
    checks++;
    if (sq.size() != 0 || lq.size() != 0) begin
      errors++; $display("FAIL R6 leftover actual=%0d expected=0", sq.size() + lq.size());
    end
    finish_run();
  end
endmodule